// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block sits beside the processor and decides what happens once the CPU has stopped executing. Software first programs two small supervisor-only registers. The first is a wake register, which holds a stop permission bit and a three-bit wake priority threshold. The second is a mode register, which holds a two-bit mode selector and a sticky "stop refused" flag. When the CPU status input shows the halted code, the block moves to doze, wait or stop, or it stays in run.

Stop mode has two conditions. The selector must ask for stop, and the permission bit must be set. If the selector asks for stop without permission, the block stays in run and records the refusal in the flag. While in any low-power mode, the block watches the pending interrupt level. A level that beats the threshold, or the top level 7, ends the mode: the block emits a one-cycle wake pulse and returns to run.

Register access from user mode is refused. The access reports a bus error, returns zero and changes nothing.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, only `modeRun` is high and `wakePulse` is low.
- R2: A read or write with `busSuper` low raises `busErr` in the same cycle, returns 0x00 and leaves every register unchanged. Supervisor accesses never raise `busErr`.
- R3: The wake register is at address 0. Bit 7 is stop permission, bits 6:4 are the wake threshold, and bits 3:0 read as zero.
- R4: The mode register is at address 1. Bits 4:3 are the selector (00 run, 01 doze, 10 wait, 11 stop) and bit 0 is the refusal flag. All other bits read as zero. Addresses 2 and 3 read as zero and ignore writes.
- R5: Mode entry happens only on the first cycle in which `cpuStatus` equals the halted code 4'hD, having differed in the cycle before. The new mode shows on the outputs after that clock edge. Selector 01 enters doze, 10 enters wait and 00 stays in run.
- R6: Stop is entered only when the selector is 11 and stop permission is 1.
- R7: With selector 11 and permission 0, a halt entry leaves the block in run and sets the refusal flag.
- R8: Writing 1 to mode register bit 0 clears the flag, and writing 0 leaves it. If a refusal and a clearing write fall in the same cycle, the flag ends up set. A halt entry uses the register values from before any write in the same cycle.
- R9: In a low-power mode, an interrupt level that is neither above the threshold nor equal to 7 is ignored, and the mode is kept.
- R10: A qualifying level moves the block to run at the sampling edge and drives `wakePulse` high for exactly the following cycle. The four mode outputs are always one-hot.
- R11: A halted status held across a wake does not re-enter a low-power mode. A fresh transition is needed.
- R12: Register writes alone never change the mode outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 2 | Register address |
| busWrData | input | 8 | Write data |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busSuper | input | 1 | Access is made in supervisor mode |
| busRdData | output | 8 | Read data, combinational |
| busErr | output | 1 | Transfer error for a user-mode access |
| cpuStatus | input | 4 | CPU processor-status code |
| irqLevel | input | 3 | Highest pending interrupt priority |
| modeRun | output | 1 | Run mode active |
| modeDoze | output | 1 | Doze mode active |
| modeWait | output | 1 | Wait mode active |
| modeStop | output | 1 | Stop mode active |
| wakePulse | output | 1 | One-cycle wake indication |

## Verification
Two events can land in the same cycle: the refusal flag being set by a refused stop, and a software write that clears that flag. The bench provokes this by raising the halted code in the same cycle as a supervisor write of 0x19 to the mode register, with permission clear. The expected outcome is the flag reading 1 afterwards, with the block still in run. A related collision, a halt entry arriving in the same cycle as a write that changes the selector, is judged against the pre-write selector. The reference model is compared on every cycle throughout.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int LVL_W = 3;

  // Field positions within the 8-bit registers
  localparam int WCR_PERMIT_BIT = 7;
  localparam int WCR_LVL_LSB    = 4;
  localparam int MCR_SEL_LSB    = 3;
  localparam int MCR_FLAG_BIT   = 0;

  localparam int ADDR_WAKE = 0;
  localparam int ADDR_MODE = 1;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_DOZE = 2'b01,
    MODE_WAIT = 2'b10,
    MODE_STOP = 2'b11
  } lpMode_t;

  localparam int NUM_MODES = 4;

  // Configuration seen by the control path
  typedef struct packed {
    logic             stopPermit;
    logic [LVL_W-1:0] wakeLvl;
    lpMode_t          modeSel;
  } lpCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic setRefused;
  } ctlStrobe_t;

endpackage

// File: rtl/lpm_regs.sv
module lpm_regs
  import lpm_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              busSuper,
  output logic [DATA_W-1:0] busRdData,
  output logic              busErr,
  input  ctlStrobe_t        strobe,
  output lpCfg_t            cfg
);

  localparam int SEL_W = $bits(lpMode_t);

  logic             permitQ;
  logic [LVL_W-1:0] lvlQ;
  lpMode_t          selQ;
  logic             refusedQ;

  logic accessAny;
  logic wrOk;
  logic rdOk;
  logic hitWake;
  logic hitMode;
  logic clearReq;

  assign accessAny = busWr | busRd;
  assign busErr    = accessAny & ~busSuper;
  assign wrOk      = busWr & busSuper;
  assign rdOk      = busRd & busSuper;
  assign hitWake   = (busAddr == ADDR_W'(ADDR_WAKE));
  assign hitMode   = (busAddr == ADDR_W'(ADDR_MODE));
  assign clearReq  = wrOk & hitMode & busWrData[MCR_FLAG_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      permitQ <= 1'b0;
      lvlQ    <= '0;
    end else if (wrOk && hitWake) begin
      permitQ <= busWrData[WCR_PERMIT_BIT];
      lvlQ    <= busWrData[WCR_LVL_LSB +: LVL_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= MODE_RUN;
    end else if (wrOk && hitMode) begin
      selQ <= lpMode_t'(busWrData[MCR_SEL_LSB +: SEL_W]);
    end
  end

  // A refusal has priority over a write-one-to-clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refusedQ <= 1'b0;
    end else if (strobe.setRefused) begin
      refusedQ <= 1'b1;
    end else if (clearReq) begin
      refusedQ <= 1'b0;
    end
  end

  always_comb begin
    busRdData = '0;
    if (rdOk) begin
      if (hitWake) begin
        busRdData[WCR_PERMIT_BIT]          = permitQ;
        busRdData[WCR_LVL_LSB +: LVL_W]    = lvlQ;
      end else if (hitMode) begin
        busRdData[MCR_SEL_LSB +: SEL_W]    = selQ;
        busRdData[MCR_FLAG_BIT]            = refusedQ;
      end
    end
  end

  assign cfg.stopPermit = permitQ;
  assign cfg.wakeLvl    = lvlQ;
  assign cfg.modeSel    = selQ;

  // R2
  user_access_no_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    busErr |=> ($stable(permitQ) && $stable(lvlQ) && $stable(selQ)));

  // R2
  user_write_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busErr && !strobe.setRefused) |=> $stable(refusedQ));

  // R8
  refusal_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setRefused |=> refusedQ);

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int          STAT_W    = 4,
  parameter logic [STAT_W-1:0] HALT_CODE = 4'hD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [STAT_W-1:0] cpuStatus,
  input  logic [LVL_W-1:0]  irqLevel,
  input  lpCfg_t            cfg,
  output ctlStrobe_t        strobe,
  output logic [NUM_MODES-1:0] modeOneHot,
  output logic              wakePulse
);

  localparam logic [LVL_W-1:0] LVL_TOP = '1;

  lpMode_t stateQ, stateD;
  logic    haltPrevQ;
  logic    haltNow;
  logic    haltRise;
  logic    wakeHit;
  logic    wakeD;
  logic    wakeQ;

  assign haltNow  = (cpuStatus == HALT_CODE);
  assign haltRise = haltNow & ~haltPrevQ;
  assign wakeHit  = (irqLevel > cfg.wakeLvl) || (irqLevel == LVL_TOP);

  always_comb begin
    stateD            = stateQ;
    wakeD             = 1'b0;
    strobe.setRefused = 1'b0;
    unique case (stateQ)
      MODE_RUN: begin
        if (haltRise) begin
          unique case (cfg.modeSel)
            MODE_DOZE: stateD = MODE_DOZE;
            MODE_WAIT: stateD = MODE_WAIT;
            MODE_STOP: begin
              if (cfg.stopPermit) stateD = MODE_STOP;
              else                strobe.setRefused = 1'b1;
            end
            default: stateD = MODE_RUN;
          endcase
        end
      end
      default: begin
        if (wakeHit) begin
          stateD = MODE_RUN;
          wakeD  = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= MODE_RUN;
      haltPrevQ <= 1'b0;
      wakeQ     <= 1'b0;
    end else begin
      stateQ    <= stateD;
      haltPrevQ <= haltNow;
      wakeQ     <= wakeD;
    end
  end

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_modeDecode
    assign modeOneHot[m] = (stateQ == lpMode_t'(m));
  end

  assign wakePulse = wakeQ;

  // R10
  mode_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(modeOneHot) == 1);

  // R10
  wake_in_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> modeOneHot[MODE_RUN]);

  // R10
  wake_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);

  // R6
  stop_needs_permit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeOneHot[MODE_STOP]) |-> $past(cfg.stopPermit));

  // R5
  entry_on_halt_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(modeOneHot[MODE_RUN]) |-> $past(haltRise));

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int STAT_W = 4,
  parameter logic [STAT_W-1:0] HALT_CODE = 4'hD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              busSuper,
  output logic [DATA_W-1:0] busRdData,
  output logic              busErr,
  input  logic [STAT_W-1:0] cpuStatus,
  input  logic [LVL_W-1:0]  irqLevel,
  output logic              modeRun,
  output logic              modeDoze,
  output logic              modeWait,
  output logic              modeStop,
  output logic              wakePulse
);

  lpCfg_t                cfg;
  ctlStrobe_t            strobe;
  logic [NUM_MODES-1:0]  modeOneHot;

  lpm_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busWr     (busWr),
    .busRd     (busRd),
    .busSuper  (busSuper),
    .busRdData (busRdData),
    .busErr    (busErr),
    .strobe    (strobe),
    .cfg       (cfg)
  );

  lpm_fsm #(
    .STAT_W    (STAT_W),
    .HALT_CODE (HALT_CODE)
  ) u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .cpuStatus  (cpuStatus),
    .irqLevel   (irqLevel),
    .cfg        (cfg),
    .strobe     (strobe),
    .modeOneHot (modeOneHot),
    .wakePulse  (wakePulse)
  );

  assign modeRun  = modeOneHot[MODE_RUN];
  assign modeDoze = modeOneHot[MODE_DOZE];
  assign modeWait = modeOneHot[MODE_WAIT];
  assign modeStop = modeOneHot[MODE_STOP];

endmodule

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;

  localparam logic [3:0] HALT = 4'hD;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] bAddr = '0;
  logic [7:0] bWd = '0;
  logic       bWr = 1'b0;
  logic       bRd = 1'b0;
  logic       bSup = 1'b0;
  logic [7:0] busRdData;
  logic       busErr;
  logic [3:0] cpu = '0;
  logic [2:0] irq = '0;
  logic       modeRun, modeDoze, modeWait, modeStop, wakePulse;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  // Reference model state
  int mMode = 0;     // 0 run, 1 doze, 2 wait, 3 stop
  int mPermit = 0;
  int mLvl = 0;
  int mSel = 0;
  int mFlag = 0;
  int mPrev = 0;
  int mPulse = 0;

  always #5 clk = ~clk;

  lpm_ctrl u_lpm_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(bAddr), .busWrData(bWd), .busWr(bWr),
    .busRd(bRd), .busSuper(bSup), .busRdData(busRdData), .busErr(busErr),
    .cpuStatus(cpu), .irqLevel(irq), .modeRun(modeRun), .modeDoze(modeDoze),
    .modeWait(modeWait), .modeStop(modeStop), .wakePulse(wakePulse)
  );

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int modelRead(int addr, int sup);
    if (!sup) return 0;
    if (addr == 0) return (mPermit << 7) | (mLvl << 4);
    if (addr == 1) return (mSel << 3) | mFlag;
    return 0;
  endfunction

  // One clock of stimulus with a full model comparison
  task automatic step(string rdTag);
    int nMode, nFlag, nPulse, haltNow;
    #1;
    chk("R2 busErr", int'(busErr), int'((bWr || bRd) && !bSup));
    if (bRd) chk(rdTag, int'(busRdData), modelRead(bAddr, bSup));
    haltNow = (cpu == HALT);
    nMode = mMode; nFlag = mFlag; nPulse = 0;
    if (mMode == 0) begin
      if (haltNow && !mPrev) begin
        if (mSel == 1) nMode = 1;
        else if (mSel == 2) nMode = 2;
        else if (mSel == 3) begin
          if (mPermit) nMode = 3;
        end
      end
    end else if (irq == 7 || irq > mLvl) begin
      nMode = 0;
      nPulse = 1;
    end
    if (bWr && bSup) begin
      if (bAddr == 0) begin mPermit = bWd[7]; mLvl = bWd[6:4]; end
      if (bAddr == 1) begin mSel = bWd[4:3]; if (bWd[0]) nFlag = 0; end
    end
    if (mMode == 0 && haltNow && !mPrev && mSel == 3 && !mPermit) nFlag = 1;
    mPrev = haltNow;
    @(posedge clk);
    @(negedge clk);
    mMode = nMode; mFlag = nFlag; mPulse = nPulse;
    chk("R5 R6 R7 R9 R11 R12 mode", int'({modeStop, modeWait, modeDoze, modeRun}), 1 << mMode);
    chk("R10 wakePulse", int'(wakePulse), mPulse);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step("idle");
  endtask

  task automatic wr(int addr, int data, int sup);
    bAddr = addr[1:0]; bWd = data[7:0]; bWr = 1'b1; bSup = sup[0];
    step("write");
    bWr = 1'b0; bSup = 1'b0;
  endtask

  task automatic rd(int addr, int sup, string tag, int exp);
    bAddr = addr[1:0]; bRd = 1'b1; bSup = sup[0];
    #1;
    chk(tag, int'(busRdData), exp);
    step(tag);
    bRd = 1'b0; bSup = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 modes", int'({modeStop, modeWait, modeDoze, modeRun}), 1);
    chk("R1 wakePulse", int'(wakePulse), 0);
    rd(0, 1, "R1 wake reg", 8'h00);
    rd(1, 1, "R1 mode reg", 8'h00);

    // R3 layout: low nibble reads zero
    wr(0, 8'hA5, 1);
    rd(0, 1, "R3 wake reg", 8'hA0);

    // R2 user-mode accesses
    wr(0, 8'h00, 0);
    wr(1, 8'h1F, 0);
    rd(0, 0, "R2 user read", 8'h00);
    rd(0, 1, "R2 wake unchanged", 8'hA0);
    rd(1, 1, "R2 mode unchanged", 8'h00);

    // R4 unused bits and addresses
    wr(1, 8'hFE, 1);
    rd(1, 1, "R4 mode reg", 8'h18);
    wr(2, 8'hFF, 1);
    rd(2, 1, "R4 spare addr", 8'h00);

    // R6 stop with permission, R12 writes left mode alone
    chk("R12 run after writes", int'(modeRun), 1);
    cpu = 4'h3; idle(1);           // non-halt code does nothing
    cpu = HALT; idle(1);
    chk("R6 stop entered", int'(modeStop), 1);
    // R9 level 2 equals threshold 2: ignored
    irq = 3'd2; idle(3);
    chk("R9 stays in stop", int'(modeStop), 1);
    irq = 3'd1; idle(1);
    // R10 level 3 wakes
    irq = 3'd3; idle(1);
    chk("R10 wake pulse", int'(wakePulse), 1);
    chk("R10 back to run", int'(modeRun), 1);
    irq = 3'd0;
    // R11 halt still held: no re-entry
    idle(3);
    chk("R11 no re-entry", int'(modeRun), 1);
    cpu = 4'h0; idle(1);

    // R7 stop refused, threshold 7
    wr(0, 8'h70, 1);
    cpu = HALT; idle(1);
    chk("R7 stays run", int'(modeRun), 1);
    cpu = 4'h0;
    rd(1, 1, "R7 flag set", 8'h19);
    // R8 write 0 keeps, write 1 clears
    wr(1, 8'h18, 1);
    rd(1, 1, "R8 flag kept", 8'h19);
    wr(1, 8'h19, 1);
    rd(1, 1, "R8 flag cleared", 8'h18);

    // R5 doze; only level 7 wakes with threshold 7
    wr(1, 8'h08, 1);
    cpu = HALT; idle(1);
    chk("R5 doze", int'(modeDoze), 1);
    irq = 3'd6; idle(2);
    chk("R9 doze kept", int'(modeDoze), 1);
    irq = 3'd7; idle(1);
    chk("R10 level 7 wake", int'(wakePulse), 1);
    irq = 3'd0; cpu = 4'h0; idle(1);

    // R5 wait
    wr(1, 8'h10, 1);
    cpu = HALT; idle(1);
    chk("R5 wait", int'(modeWait), 1);
    irq = 3'd7; idle(1);
    irq = 3'd0; cpu = 4'h0; idle(1);

    // R5 selector run: no entry
    wr(1, 8'h00, 1);
    cpu = HALT; idle(2);
    chk("R5 run selector", int'(modeRun), 1);
    cpu = 4'h0; idle(1);

    // R8 collision: refusal and clear write together
    wr(1, 8'h18, 1);
    bAddr = 2'd1; bWd = 8'h19; bWr = 1'b1; bSup = 1'b1; cpu = HALT;
    step("R8 collide");
    bWr = 1'b0; bSup = 1'b0; cpu = 4'h0;
    rd(1, 1, "R8 set wins", 8'h19);

    // R8 halt uses pre-write selector: write doze while halting with selector run
    wr(1, 8'h01, 1);
    bAddr = 2'd1; bWd = 8'h08; bWr = 1'b1; bSup = 1'b1; cpu = HALT;
    step("R8 pre-write");
    bWr = 1'b0; bSup = 1'b0;
    chk("R8 old selector used", int'(modeRun), 1);
    cpu = 4'h0; idle(2);

    finishRun();
  end

endmodule